// File: doc/BRIEF.md
# Multi-Mode General-Purpose Timer

This block is a general-purpose timer with one shared counter and one bidirectional pin. It runs in one of three modes. In waveform mode it drives a pulse train on the pin from a programmed period and high time. In capture mode it takes the pin as an input and measures the period and high time of an incoming pulse. In event mode it counts rising edges on the pin and raises an interrupt when a programmed count is reached.

Software reaches five word-wide registers through a simple write port and a combinational read port. The registers are a 6-bit mode word, the counter, the period, the pulse width, and a control/status word. The status word holds the enable bit and two sticky flags, each cleared by writing 1. The pin's output enable follows the mode. The interrupt line is the sticky event flag gated by the interrupt-enable bit of the mode word.

Top module: `gp_timer`

Register addresses: 0 mode word, 1 counter, 2 period, 3 pulse width, 4 control/status. Control/status bit 0 is the enable, bit 1 the event flag and bit 2 the wrap flag.

Mode word fields:
- bits [1:0]: mode, where 0 is idle, 1 waveform, 2 capture and 3 event counting.
- bit 2: invert the pin level.
- bit 3: interrupt enable.
- bit 4: in capture mode, the event is raised on the falling edge (1) instead of the rising edge (0).
- bit 5: spare, stored only.

## Requirements
- R1: After reset every register reads 0, and pin_o, pin_oe and irq are all 0.
- R2: In waveform mode with enable set and period P of at least 2, the counter runs 0..P-1 and wraps to 0. The pin is active while the counter is below the width W and inactive otherwise. pin_oe is 1.
- R3: In waveform mode the event flag (status bit 1) sets when the counter wraps from P-1 to 0. irq is 1 while that flag is set and mode bit 3 is 1.
- R4: Mode bit 2 inverts the pin level, so the active level is low.
- R5: In waveform mode a period of 0 or 1 holds the counter at 0 and the pin inactive, and never sets the event flag.
- R6: In waveform mode a width not smaller than the period holds the pin active for the whole cycle.
- R7: In capture mode pin_oe is 0 and the pin passes through a two-flop synchronizer. On each rising edge the period register takes the cycles since the previous rising edge and the counter restarts. On each falling edge the width register takes the cycles the pin was high.
- R8: In capture mode the event flag sets on a rising edge when mode bit 4 is 0, and on a falling edge when it is 1.
- R9: In capture mode a counter step from all ones to 0 sets the sticky wrap flag (status bit 2).
- R10: In event mode each synchronized rising edge adds 1 to the counter. When the count reaches the period, the counter returns to 0 and the event flag sets.
- R11: Writing 1 to status bit 1 or 2 clears that flag, and writing 0 leaves it set. Status bit 0 is the plain enable.
- R12: While disabled, the counter holds its value, no flag sets and pin_oe is 0.
- R13: The mode word keeps only bits [5:0] of a write and reads the rest as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wr_data | input | W | Write data |
| rd_data | output | W | Read data of the addressed register |
| pin_i | input | 1 | Pin level from the pad |
| pin_o | output | 1 | Pin level to the pad |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench steps the waveform counter through whole periods and checks the pin in every cycle. A design that reloads one count late or compares the width with the wrong relation gives a pulse train one cycle off. It also drives the degenerate settings: a period of 1, a width past the period, and an inverted pin. A design that lets these through would toggle the pin or set the flag when it must not. In capture mode it feeds a known high and low time and preloads the counter just below its wrap. This exposes an off-by-one in the latched width or period, and a wrap flag that never sets or fails to stay set. In event mode it counts single pulses up to the period, so a design that counts levels instead of edges, or misses the reload, leaves the wrong count.

// File: rtl/gpt_pkg.sv
package gpt_pkg;

    typedef enum logic [1:0] {
        MODE_IDLE = 2'd0,
        MODE_WAVE = 2'd1,
        MODE_CAPT = 2'd2,
        MODE_EVNT = 2'd3
    } gpt_mode_e;

    typedef struct packed {
        logic      spare;
        logic      cap_on_fall;
        logic      irq_en;
        logic      invert;
        gpt_mode_e mode;
    } gpt_cfg_t;

    localparam int CFG_BITS = $bits(gpt_cfg_t);

    localparam logic [2:0] ADR_CFG  = 3'd0;
    localparam logic [2:0] ADR_CNT  = 3'd1;
    localparam logic [2:0] ADR_PER  = 3'd2;
    localparam logic [2:0] ADR_WID  = 3'd3;
    localparam logic [2:0] ADR_STAT = 3'd4;

    localparam int ST_EN   = 0;
    localparam int ST_FLAG = 1;
    localparam int ST_WRAP = 2;

    function automatic logic is_mode(gpt_cfg_t c, gpt_mode_e m);
        return c.mode == m;
    endfunction

endpackage

// File: rtl/gpt_sync.sv
module gpt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic rise,
    output logic fall
);
    logic [STAGES-1:0] sh_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
        end else begin
            sh_q   <= {sh_q[STAGES-2:0], d};
            prev_q <= sh_q[STAGES-1];
        end
    end

    assign rise = sh_q[STAGES-1] & ~prev_q;
    assign fall = ~sh_q[STAGES-1] & prev_q;
endmodule

// File: rtl/gpt_core.sv
module gpt_core
    import gpt_pkg::*;
#(
    parameter int W = 32
) (
    input  gpt_cfg_t       cfg,
    input  logic           en,
    input  logic [W-1:0]   cnt,
    input  logic [W-1:0]   per,
    input  logic [W-1:0]   wid,
    input  logic           rise,
    input  logic           fall,
    output logic [W-1:0]   cnt_nxt,
    output logic           per_ld,
    output logic           wid_ld,
    output logic [W-1:0]   cap_val,
    output logic           evt,
    output logic           wrap,
    output logic           active
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    logic [W-1:0] inc;
    assign inc     = cnt + ONE;
    assign cap_val = inc;

    always_comb begin
        cnt_nxt = cnt;
        per_ld  = 1'b0;
        wid_ld  = 1'b0;
        evt     = 1'b0;
        wrap    = 1'b0;
        active  = 1'b0;
        if (en) begin
            unique case (cfg.mode)
                MODE_WAVE: begin
                    if (per < TWO) begin
                        cnt_nxt = '0;
                    end else begin
                        active = (cnt < wid);
                        if (cnt >= per - ONE) begin
                            cnt_nxt = '0;
                            evt     = 1'b1;
                        end else begin
                            cnt_nxt = inc;
                        end
                    end
                end
                MODE_CAPT: begin
                    if (rise) begin
                        per_ld  = 1'b1;
                        cnt_nxt = '0;
                        evt     = ~cfg.cap_on_fall;
                    end else begin
                        cnt_nxt = inc;
                        wrap    = &cnt;
                    end
                    if (fall) begin
                        wid_ld = 1'b1;
                        evt    = cfg.cap_on_fall;
                    end
                end
                MODE_EVNT: begin
                    if (rise) begin
                        if (inc == per) begin
                            cnt_nxt = '0;
                            evt     = 1'b1;
                        end else begin
                            cnt_nxt = inc;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gp_timer.sv
module gp_timer
    import gpt_pkg::*;
#(
    parameter int W           = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    input  logic         pin_i,
    output logic         pin_o,
    output logic         pin_oe,
    output logic         irq
);
    gpt_cfg_t     cfg_q;
    logic         en_q, flag_q, wrap_q;
    logic [W-1:0] cnt_q, per_q, wid_q;

    logic         rise, fall;
    logic [W-1:0] cnt_nxt, cap_val;
    logic         per_ld, wid_ld, evt, wrap, active;

    gpt_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pin_i),
        .rise(rise),
        .fall(fall)
    );

    gpt_core #(.W(W)) core_i (
        .cfg    (cfg_q),
        .en     (en_q),
        .cnt    (cnt_q),
        .per    (per_q),
        .wid    (wid_q),
        .rise   (rise),
        .fall   (fall),
        .cnt_nxt(cnt_nxt),
        .per_ld (per_ld),
        .wid_ld (wid_ld),
        .cap_val(cap_val),
        .evt    (evt),
        .wrap   (wrap),
        .active (active)
    );

    logic wr_cfg, wr_cnt, wr_per, wr_wid, wr_st;
    assign wr_cfg = wr_en && addr == ADR_CFG;
    assign wr_cnt = wr_en && addr == ADR_CNT;
    assign wr_per = wr_en && addr == ADR_PER;
    assign wr_wid = wr_en && addr == ADR_WID;
    assign wr_st  = wr_en && addr == ADR_STAT;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            en_q   <= 1'b0;
            flag_q <= 1'b0;
            wrap_q <= 1'b0;
            cnt_q  <= '0;
            per_q  <= '0;
            wid_q  <= '0;
        end else begin
            cfg_q  <= wr_cfg ? gpt_cfg_t'(wr_data[CFG_BITS-1:0]) : cfg_q;
            en_q   <= wr_st ? wr_data[ST_EN] : en_q;
            flag_q <= evt  | (flag_q & ~(wr_st & wr_data[ST_FLAG]));
            wrap_q <= wrap | (wrap_q & ~(wr_st & wr_data[ST_WRAP]));
            cnt_q  <= wr_cnt ? wr_data : cnt_nxt;
            if (wr_per)      per_q <= wr_data;
            else if (per_ld) per_q <= cap_val;
            if (wr_wid)      wid_q <= wr_data;
            else if (wid_ld) wid_q <= cap_val;
        end
    end

    always_comb begin
        unique case (addr)
            ADR_CFG:  rd_data = W'(cfg_q);
            ADR_CNT:  rd_data = cnt_q;
            ADR_PER:  rd_data = per_q;
            ADR_WID:  rd_data = wid_q;
            ADR_STAT: rd_data = W'({wrap_q, flag_q, en_q});
            default:  rd_data = '0;
        endcase
    end

    assign pin_o  = active ^ cfg_q.invert;
    assign pin_oe = en_q && is_mode(cfg_q, MODE_WAVE);
    assign irq    = flag_q & cfg_q.irq_en;
endmodule

// File: rtl/gpt_checker.sv
module gpt_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         wr_en,
    input logic [2:0]   addr,
    input logic [W-1:0] wr_data,
    input logic [5:0]   cfg,
    input logic         en,
    input logic [W-1:0] cnt,
    input logic [W-1:0] per,
    input logic         flag,
    input logic         wrap,
    input logic         pin_o,
    input logic         pin_oe
);
    localparam logic [W-1:0] ONE = W'(1);
    localparam logic [W-1:0] TWO = W'(2);

    logic wave, capt;
    assign wave = en && cfg[1:0] == 2'd1;
    assign capt = en && cfg[1:0] == 2'd2;

    p_wave_range_r2: assert property (@(posedge clk) disable iff (rst)
        wave && per >= TWO && cnt < per && !wr_en |=> cnt < per);

    p_wave_reload_r3: assert property (@(posedge clk) disable iff (rst)
        wave && per >= TWO && cnt == per - ONE && !wr_en |=> cnt == '0 && flag);

    p_short_idle_r5: assert property (@(posedge clk) disable iff (rst)
        wave && per < TWO |-> pin_o == cfg[2]);

    p_capt_input_r7: assert property (@(posedge clk) disable iff (rst)
        capt |-> !pin_oe);

    p_wrap_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        wrap && !(wr_en && addr == 3'd4 && wr_data[2]) |=> wrap);

    p_flag_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        flag && !(wr_en && addr == 3'd4 && wr_data[1]) |=> flag);

    p_hold_off_r12: assert property (@(posedge clk) disable iff (rst)
        !en && !wr_en |=> $stable(cnt));
endmodule

bind gp_timer gpt_checker #(.W(W)) chk_i (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en),
    .addr   (addr),
    .wr_data(wr_data),
    .cfg    (cfg_q),
    .en     (en_q),
    .cnt    (cnt_q),
    .per    (per_q),
    .flag   (flag_q),
    .wrap   (wrap_q),
    .pin_o  (pin_o),
    .pin_oe (pin_oe)
);

// File: tb/gp_timer_tb.sv
module gp_timer_tb_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [2:0]   addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         pin_i = 1'b0;
    logic         pin_o, pin_oe, irq;

    always #5 clk = ~clk;

    gp_timer #(.W(W)) dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .irq(irq)
    );

    typedef struct {
        string        tag;
        int           src;
        logic [W-1:0] exp;
    } item_t;

    item_t q[$];
    int    checks = 0;
    int    fails  = 0;
    bit    done   = 0;

    // monitor: pops expected items and compares against the ports mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            while (q.size() > 0) begin
                item_t it;
                logic [W-1:0] act;
                it = q.pop_front();
                case (it.src)
                    0:       act = rd_data;
                    1:       act = W'(pin_o);
                    2:       act = W'(pin_oe);
                    default: act = W'(irq);
                endcase
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_sig(int src, logic [W-1:0] exp, string tag);
        item_t it;
        it.tag = tag; it.src = src; it.exp = exp;
        q.push_back(it);
    endtask

    task automatic expect_reg(logic [2:0] a, logic [W-1:0] exp, string tag);
        addr = a;
        expect_sig(0, exp, tag);
    endtask

    task automatic step(int n);
        wait (q.size() == 0);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(logic [2:0] a, logic [W-1:0] d);
        wait (q.size() == 0);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic pin_pulse(int hi, int lo);
        wait (q.size() == 0);
        pin_i = 1'b1;
        step(hi);
        pin_i = 1'b0;
        step(lo);
    endtask

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] held;
        step(3);
        rst = 1'b0;
        step(1);

        // R1 reset state
        expect_reg(3'd0, 0, "R1 cfg");
        step(1);
        expect_reg(3'd1, 0, "R1 cnt");
        step(1);
        expect_reg(3'd2, 0, "R1 per");
        step(1);
        expect_reg(3'd3, 0, "R1 wid");
        step(1);
        expect_reg(3'd4, 0, "R1 stat");
        expect_sig(1, 0, "R1 pin_o");
        expect_sig(2, 0, "R1 pin_oe");
        expect_sig(3, 0, "R1 irq");
        step(1);

        // R13 mode word width
        wr(3'd0, 32'hFFFF_FFC8);
        expect_reg(3'd0, 32'h08, "R13 cfg mask");
        step(1);

        // R2 / R3 waveform P=5 W=2 with irq enabled
        wr(3'd0, 32'h09);
        wr(3'd2, 5);
        wr(3'd3, 2);
        wr(3'd1, 0);
        wr(3'd4, 1);
        for (int i = 0; i < 12; i++) begin
            expect_sig(1, W'((i % 5) < 2), "R2 wave level");
            expect_sig(2, 1, "R2 pin_oe");
            if (i < 5) expect_sig(3, 0, "R3 irq before wrap");
            step(1);
        end
        expect_reg(3'd4, 3, "R3 flag after wrap");
        expect_sig(3, 1, "R3 irq");
        step(1);

        // R11 write 0 keeps flag, write 1 clears
        wr(3'd4, 0);
        expect_reg(3'd4, 2, "R11 flag kept on zero write");
        step(1);
        wr(3'd4, 2);
        expect_reg(3'd4, 0, "R11 flag cleared");
        expect_sig(3, 0, "R11 irq low");
        step(1);

        // R12 disabled counter holds
        addr = 3'd1;
        @(negedge clk);
        held = rd_data;
        step(5);
        expect_reg(3'd1, held, "R12 cnt held");
        expect_sig(2, 0, "R12 pin_oe off");
        step(1);

        // R4 inverted pin, P=4 W=1
        wr(3'd0, 32'h05);
        wr(3'd2, 4);
        wr(3'd3, 1);
        wr(3'd1, 0);
        wr(3'd4, 1);
        for (int i = 0; i < 8; i++) begin
            expect_sig(1, W'(!((i % 4) < 1)), "R4 inverted level");
            step(1);
        end
        wr(3'd4, 6);

        // R6 width past period
        wr(3'd0, 32'h01);
        wr(3'd3, 7);
        wr(3'd1, 0);
        wr(3'd4, 1);
        for (int i = 0; i < 8; i++) begin
            expect_sig(1, 1, "R6 held active");
            step(1);
        end
        wr(3'd4, 6);

        // R5 period 1 is idle
        wr(3'd0, 32'h09);
        wr(3'd2, 1);
        wr(3'd3, 1);
        wr(3'd1, 0);
        wr(3'd4, 1);
        for (int i = 0; i < 10; i++) begin
            expect_sig(1, 0, "R5 pin idle");
            step(1);
        end
        expect_reg(3'd1, 0, "R5 cnt at zero");
        step(1);
        expect_reg(3'd4, 1, "R5 no flag");
        step(1);
        wr(3'd4, 6);

        // R7 / R8 capture, event on rising edge
        pin_i = 1'b0;
        wr(3'd0, 32'h0A);
        wr(3'd2, 0);
        wr(3'd3, 0);
        wr(3'd1, 0);
        wr(3'd4, 1);
        expect_sig(2, 0, "R7 pin_oe input");
        expect_reg(3'd4, 1, "R8 no flag before edge");
        step(4);
        for (int k = 0; k < 3; k++) pin_pulse(3, 5);
        step(6);
        expect_reg(3'd2, 8, "R7 period");
        step(1);
        expect_reg(3'd3, 3, "R7 width");
        step(1);
        expect_reg(3'd4, 3, "R8 flag on rise");
        expect_sig(3, 1, "R8 irq");
        step(1);

        // R8 capture, event on falling edge
        wr(3'd4, 6);
        wr(3'd0, 32'h1A);
        wr(3'd4, 1);
        pin_i = 1'b1;
        step(6);
        expect_reg(3'd4, 1, "R8 rise ignored when on-fall");
        step(1);
        pin_i = 1'b0;
        step(6);
        expect_reg(3'd4, 3, "R8 flag on fall");
        step(1);
        wr(3'd4, 6);

        // R9 capture wrap
        wr(3'd0, 32'h02);
        wr(3'd1, 32'hFFFF_FFFE);
        wr(3'd4, 1);
        expect_reg(3'd4, 1, "R9 no wrap yet");
        step(3);
        expect_reg(3'd4, 5, "R9 wrap flag");
        step(3);
        expect_reg(3'd4, 5, "R9 wrap sticky");
        step(1);
        wr(3'd4, 4);
        expect_reg(3'd4, 0, "R9 wrap cleared");
        step(1);

        // R10 event counting to period 3
        wr(3'd0, 32'h0B);
        wr(3'd2, 3);
        wr(3'd1, 0);
        wr(3'd4, 1);
        pin_pulse(2, 2);
        pin_pulse(2, 2);
        step(6);
        expect_reg(3'd1, 2, "R10 two events");
        expect_sig(2, 0, "R10 pin_oe input");
        step(1);
        expect_reg(3'd4, 1, "R10 no flag yet");
        step(1);
        pin_pulse(2, 2);
        step(6);
        expect_reg(3'd1, 0, "R10 reload at period");
        step(1);
        expect_reg(3'd4, 3, "R10 flag at period");
        expect_sig(3, 1, "R10 irq");
        step(1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule